// File: doc/BRIEF.md
# Leading-One Window Approximate Multiplier

This block multiplies two 8-bit two's-complement operands approximately, in pure combinational logic. It does not form the full 8x8 product. For each operand it finds the highest bit that holds a 1 and cuts a 4-bit window whose top bit is that 1. It then notes how many places the window sits above bit 0. The two windows are multiplied in a small 4x4 core, and the product is shifted left by the sum of the two window offsets. The result is a 16-bit value close to the true product, built from a fraction of the partial-product logic.

The sign bits of the two operands choose how each window enters the small multiply. When the signs agree, both windows are plain unsigned numbers. When only one operand has its sign bit set, that operand's window is read as a signed 4-bit number. The other window gets one leading zero bit so that it stays non-negative, and the multiply runs in signed arithmetic. The block suits datapaths that can tolerate a bounded error in exchange for a much smaller multiplier.

Top module: `dsm_approx_mult`

## Requirements
- R1: The block is combinational. `prod_o` follows any change on `op_a` or `op_b` with no clock edge involved.
- R2: For each operand, let k be the index of its highest 1 bit. When k is 3 or more, the window is bits k down to k-3 of the operand.
- R3: The window offset is k-3 when k is 3 or more. When k is 2 or less, the offset is 0 and the window is bits 3..0 of the operand. For example, 0x08 gives window 8 with offset 0, and 0x10 gives window 8 with offset 1.
- R4: `prod_o` is the window product shifted left by the sum of both offsets, truncated to 16 bits. Example: 0x7F times 0x7F gives 15*15 shifted by 6, which is 0x3840.
- R5: When bit 7 of `op_a` equals bit 7 of `op_b` (sign pair 00 or 11), both windows are read as unsigned values from 0 to 15. Example: 0xFF times 0xFF gives 225 shifted by 8, which is 0xE100.
- R6: When only bit 7 of `op_b` is set (sign pair 01), the window of `op_a` is zero-extended and the window of `op_b` is read as signed 4-bit. The signed product is sign-extended to 16 bits before the shift. Example: 0x01 times 0xFF gives 0xFFF0.
- R7: When only bit 7 of `op_a` is set (sign pair 10), the roles are swapped: the window of `op_a` is signed and the window of `op_b` is zero-extended. Example: 0x80 times 0x7F gives -8*15 shifted by 7, which is 0xC400.
- R8: If either operand is zero, its window and offset are zero and `prod_o` is 0.
- R9: When both operands lie between 0 and 15, `prod_o` equals the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand, two's complement |
| op_b | input | 8 | Second operand, two's complement |
| prod_o | output | 16 | Approximate product |

## Verification
The hardest case to reach is the largest shift paired with a signed window. That happens when a negative operand (window taken from bits 7..4, offset 4) meets a positive operand whose leading one sits at bit 6. This is the only way the 16-bit result approaches its negative limit, and it is the most likely place for a truncation or sign-extension fault to show. The directed table places operands at exactly these leading-one positions. An exhaustive sweep of all 65536 operand pairs then covers every combination of window, offset and sign pair, checked against an independent model in the bench.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  // Sign bits of (op_a, op_b), concatenated with op_a in the upper bit.
  typedef enum logic [1:0] {
    SGN_BOTH_POS = 2'b00,
    SGN_B_NEG    = 2'b01,
    SGN_A_NEG    = 2'b10,
    SGN_BOTH_NEG = 2'b11
  } sign_pair_e;

endpackage

// File: rtl/dsm_lead_one.sv
module dsm_lead_one #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Priority scan: the highest set bit is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    if (found) begin
      AST_LEAD_IS_SET: assert (vec[idx]) else $error("leading bit not set"); // R2
      AST_NOTHING_ABOVE: assert ((vec >> idx) == W'(1)) else $error("set bit above leading one"); // R2
    end else begin
      AST_EMPTY_IS_ZERO: assert (vec == '0) else $error("no leading one on nonzero vector"); // R8
    end
  end

endmodule

// File: rtl/dsm_segment.sv
module dsm_segment #(
  parameter int OP_W  = 8,
  parameter int SEG_W = 4,
  localparam int IW    = $clog2(OP_W),
  localparam int MAXOF = OP_W - SEG_W,
  localparam int OFF_W = $clog2(MAXOF + 1)
) (
  input  logic [OP_W-1:0]  opnd,
  output logic [SEG_W-1:0] seg,
  output logic [OFF_W-1:0] offset
);

  logic          lead_found;
  logic [IW-1:0] lead_idx;

  dsm_lead_one #(.W(OP_W)) u_lead (
    .vec   (opnd),
    .found (lead_found),
    .idx   (lead_idx)
  );

  always_comb begin
    if (lead_found && (lead_idx >= IW'(SEG_W - 1))) begin
      offset = OFF_W'(lead_idx - IW'(SEG_W - 1));
    end else begin
      offset = '0;
    end
    seg = SEG_W'(opnd >> offset);
    if (offset != '0) begin
      AST_WINDOW_TOP_SET: assert (seg[SEG_W-1]) else $error("window top bit clear"); // R3
    end
    if (opnd == '0) begin
      AST_ZERO_WINDOW: assert (seg == '0 && offset == '0) else $error("zero operand window"); // R8
    end
  end

endmodule

// File: rtl/dsm_seg_mult.sv
module dsm_seg_mult
  import dsm_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int RES_W = 16,
  parameter int SH_W  = 4,
  localparam int PW    = 2 * SEG_W + 2,
  localparam int MAX_U = (2**SEG_W - 1) * (2**SEG_W - 1),
  localparam int MIN_S = -(2**(SEG_W-1)) * (2**SEG_W - 1)
) (
  input  logic [SEG_W-1:0] seg_a,
  input  logic [SEG_W-1:0] seg_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [SH_W-1:0]  shamt,
  output logic [RES_W-1:0] result
);

  sign_pair_e            pair;
  logic                  a_signed;
  logic                  b_signed;
  logic signed [PW-1:0]  ext_a;
  logic signed [PW-1:0]  ext_b;
  logic signed [PW-1:0]  prod;

  always_comb begin
    pair     = sign_pair_e'({sign_a, sign_b});
    a_signed = 1'b0;
    b_signed = 1'b0;
    case (pair)
      SGN_BOTH_POS, SGN_BOTH_NEG: begin
        a_signed = 1'b0;
        b_signed = 1'b0;
      end
      SGN_B_NEG: b_signed = 1'b1;
      SGN_A_NEG: a_signed = 1'b1;
      default: begin
        a_signed = 1'b0;
        b_signed = 1'b0;
      end
    endcase
    ext_a  = a_signed ? PW'($signed(seg_a)) : PW'({1'b0, seg_a});
    ext_b  = b_signed ? PW'($signed(seg_b)) : PW'({1'b0, seg_b});
    prod   = ext_a * ext_b;
    result = RES_W'(prod) <<< shamt;

    AST_PROD_RANGE: assert (int'(prod) <= MAX_U && int'(prod) >= MIN_S) else $error("window product out of range"); // R4
    if (!a_signed && !b_signed) begin
      AST_UNS_NONNEG: assert (!prod[PW-1]) else $error("unsigned mode gave negative product"); // R5
    end
    if (seg_a == '0 || seg_b == '0) begin
      AST_ZERO_RESULT: assert (result == '0) else $error("zero window gave nonzero result"); // R8
    end
  end

endmodule

// File: rtl/dsm_approx_mult.sv
module dsm_approx_mult #(
  parameter int OP_W  = 8,
  parameter int SEG_W = 4,
  localparam int RES_W = 2 * OP_W,
  localparam int OFF_W = $clog2(OP_W - SEG_W + 1),
  localparam int SH_W  = OFF_W + 1
) (
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [RES_W-1:0] prod_o
);

  logic [OP_W-1:0]  ops  [2];
  logic [SEG_W-1:0] segs [2];
  logic [OFF_W-1:0] offs [2];
  logic [SH_W-1:0]  shamt;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_window
    dsm_segment #(.OP_W(OP_W), .SEG_W(SEG_W)) u_seg (
      .opnd   (ops[g]),
      .seg    (segs[g]),
      .offset (offs[g])
    );
  end

  assign shamt = SH_W'(offs[0]) + SH_W'(offs[1]);

  dsm_seg_mult #(.SEG_W(SEG_W), .RES_W(RES_W), .SH_W(SH_W)) u_mult (
    .seg_a  (segs[0]),
    .seg_b  (segs[1]),
    .sign_a (op_a[OP_W-1]),
    .sign_b (op_b[OP_W-1]),
    .shamt  (shamt),
    .result (prod_o)
  );

endmodule

// File: tb/dsm_approx_mult_test.sv
module dsm_approx_mult_test;

  logic        clk;
  logic [7:0]  op_a;
  logic [7:0]  op_b;
  logic [15:0] prod_o;
  int          n_chk;
  int          n_fail;
  bit          done;

  dsm_approx_mult uut (
    .op_a   (op_a),
    .op_b   (op_b),
    .prod_o (prod_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {op_a, op_b, expected}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h55, 16'h0000},
    {8'h05, 8'h07, 16'h0023},
    {8'h64, 8'h0A, 16'h03C0},
    {8'hFF, 8'hFF, 16'hE100},
    {8'h01, 8'hFF, 16'hFFF0},
    {8'h80, 8'h7F, 16'hC400},
    {8'h7F, 8'h7F, 16'h3840},
    {8'h08, 8'h10, 16'h0080},
    {8'h90, 8'h03, 16'hFEB0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R8";
      1: return "R9";
      2: return "R2";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R4";
      7: return "R3";
      default: return "R7";
    endcase
  endfunction

  // Independent model written from the requirements.
  function automatic logic [15:0] model(input logic [7:0] x, input logic [7:0] y);
    int kx, ky, ox, oy, sx, sy, p;
    kx = -1; ky = -1;
    for (int i = 7; i >= 0; i--) begin
      if (kx < 0 && x[i]) kx = i;
      if (ky < 0 && y[i]) ky = i;
    end
    ox = (kx >= 3) ? kx - 3 : 0;
    oy = (ky >= 3) ? ky - 3 : 0;
    sx = (int'(x) >> ox) % 16;
    sy = (int'(y) >> oy) % 16;
    if (x[7] && !y[7] && sx >= 8) sx = sx - 16;
    if (y[7] && !x[7] && sy >= 8) sy = sy - 16;
    p = sx * sy * (1 << (ox + oy));
    return p[15:0];
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h got %h expected %h", tag, op_a, op_b, got, exp);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    op_a = 8'h00; op_b = 8'h00;
    @(negedge clk);
    check(prod_o, 16'h0000, "R8");

    // R1: output settles between edges, no clock involved
    #1 op_a = 8'h03; op_b = 8'h03;
    #1 check(prod_o, 16'h0009, "R1");
    #1 op_b = 8'h06;
    #1 check(prod_o, 16'h0012, "R1");

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      op_a = VEC[i][31:24];
      op_b = VEC[i][23:16];
      @(negedge clk);
      check(prod_o, VEC[i][15:0], tag_of(i));
    end

    // R9: small operands are exact
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      op_a = 8'(i); op_b = 8'(15 - i);
      @(negedge clk);
      check(prod_o, 16'(i * (15 - i)), "R9");
    end

    // Exhaustive sweep (R2 R3 R4 R5 R6 R7 R8) plus error statistics
    begin
      real err_sum;
      int  err_n;
      err_sum = 0.0; err_n = 0;
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          @(posedge clk);
          op_a = 8'(a); op_b = 8'(b);
          @(negedge clk);
          check(prod_o, model(op_a, op_b), "R4");
          if (a != 0 && b != 0) begin
            int ex, ap;
            ex = int'($signed(op_a)) * int'($signed(op_b));
            ap = int'($signed(prod_o));
            err_sum = err_sum + ((ap > ex) ? real'(ap - ex) : real'(ex - ap)) /
                      ((ex > 0) ? real'(ex) : real'(-ex));
            err_n++;
          end
        end
      end
      $display("Mean relative error over %0d nonzero pairs: %f", err_n, err_sum / real'(err_n));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog expired, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule